// File: doc/BRIEF.md
# Power-aware banked word memory

This block is a synchronous memory with one write port and one read port on a single clock. The logical store is split by depth into several banks. In the default layout each bank is as wide as the full word. The top address bits pick one bank, and only that bank receives an enable for the access. The port enables are turned directly into per-bank clock enables, so an idle port touches no bank at all. A multiplexer, steered by the registered bank select, returns the word from the bank that was read.

A parameter can instead build the same logical memory from bit slices. In that layout every bank takes part in every access, which makes it a reference for comparing enable activity. A second parameter chooses between two modes. In conversion mode only the port enable counts. In combining mode a per-port user clock enable is ANDed with the port enable.

Each bank exposes two counters, one for the write-enabled cycles it has seen and one for the read-enabled cycles. A bench can therefore see at the ports exactly which banks were enabled.

Top module: `banked_ram`

## Requirements
- R1: With default parameters the memory holds 4096 words of 4 bits in 4 banks of 1024 rows. Address bits [9:0] address the row inside a bank, and bits [11:10] give the bank number.
- R2: A word written at an address is returned on `rd_data` one clock after a read of that address is accepted.
- R3: In banked mode (VERTICAL=0), a cycle with an accepted access of one port increments that port's counter of bank addr[11:10] by one. No other counter of that port changes.
- R4: When a port's effective enable is low, none of that port's bank counters changes, and a write stores nothing.
- R5: With COMBINE=1, a port's effective enable is its enable ANDed with its user clock enable. A low clock enable blocks the access completely.
- R6: With COMBINE=0, the user clock enables are ignored, and an access happens whenever the port enable is high.
- R7: `rd_data` keeps its last value in every cycle without an accepted read.
- R8: A read and a write to the same address in the same cycle return the data held before that write.
- R9: With VERTICAL=1, every bank counter of a port increments on each accepted access of that port, and the read and write data still match R2.
- R10: Bank b's counters sit at bits [b*CNT_W +: CNT_W] of `wr_cnt_o` and `rd_cnt_o`. Each counter is CNT_W bits wide and wraps around.
- R11: While `rst_n` is low, `rd_data` and all counters are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of read data and counters |
| wr_en | input | 1 | Write request |
| wr_ce | input | 1 | User clock enable for the write port (combining mode only) |
| wr_addr | input | AW | Write word address |
| wr_data | input | WIDTH | Write word |
| rd_en | input | 1 | Read request |
| rd_ce | input | 1 | User clock enable for the read port (combining mode only) |
| rd_addr | input | AW | Read word address |
| rd_data | output | WIDTH | Read word, one clock latency, held when idle |
| wr_cnt_o | output | NBANKS*CNT_W | Per-bank count of write-enabled cycles |
| rd_cnt_o | output | NBANKS*CNT_W | Per-bank count of read-enabled cycles |

## Verification
A write and a read can land in the same cycle. When they share an address, the read must return the older word. When they hit different banks, one bank gets a write enable and another gets a read enable, and the two counter sets must each move by exactly one in the right bank. Both cases are driven directly and also arise often in a long stretch of stimulus restricted to a small address pool. A behavioural model in the bench, built from associative arrays and per-bank integers, predicts the read word and every counter for each clock. That model covers three instances: banked with combining, banked with conversion, and bit-sliced.

// File: rtl/bram_pkg.sv
package bram_pkg;
  // bank number carried in the top sw bits of an aw-bit address
  function automatic int unsigned bank_of(input logic [31:0] a, input int unsigned aw,
                                          input int unsigned sw);
    return int'((a >> (aw - sw)) & ((32'd1 << sw) - 32'd1));
  endfunction

  // effective enable of a port under the chosen enable mode
  function automatic logic port_go(input logic en, input logic ce, input bit combine);
    return combine ? (en & ce) : en;
  endfunction
endpackage

// File: rtl/bank_enable_ctl.sv
module bank_enable_ctl #(
  parameter int AW       = 12,
  parameter int NBANKS   = 4,
  parameter bit VERTICAL = 1'b0,
  parameter bit COMBINE  = 1'b1,
  localparam int SW      = $clog2(NBANKS)
) (
  input  logic              en,
  input  logic              ce,
  input  logic [AW-1:0]     addr,
  output logic              go,
  output logic [SW-1:0]     sel,
  output logic [NBANKS-1:0] bank_en
);
  assign go  = bram_pkg::port_go(en, ce, COMBINE);
  assign sel = SW'(bram_pkg::bank_of(32'(addr), AW, SW));

  for (genvar b = 0; b < NBANKS; b++) begin : g_en
    if (VERTICAL) begin : g_all
      assign bank_en[b] = go;
    end else begin : g_one
      assign bank_en[b] = go & (sel == SW'(b));
    end
  end
endmodule

// File: rtl/ram_bank.sv
module ram_bank #(
  parameter int ROWS  = 1024,
  parameter int COLS  = 4,
  parameter int CNT_W = 16,
  localparam int RW   = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [RW-1:0]    waddr,
  input  logic [COLS-1:0]  wdata,
  input  logic             re,
  input  logic [RW-1:0]    raddr,
  output logic [COLS-1:0]  rdata,
  output logic [CNT_W-1:0] wr_cnt,
  output logic [CNT_W-1:0] rd_cnt
);
  logic [COLS-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // read samples the array before the write of the same edge lands
  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_cnt <= '0;
      rd_cnt <= '0;
    end else begin
      if (we) wr_cnt <= wr_cnt + 1'b1;
      if (re) rd_cnt <= rd_cnt + 1'b1;
    end
  end

  assert_wcnt_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> wr_cnt == CNT_W'($past(wr_cnt) + 1'b1));
  assert_rcnt_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rd_cnt));
  assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rdata));
endmodule

// File: rtl/banked_ram.sv
module banked_ram #(
  parameter int DEPTH    = 4096,
  parameter int WIDTH    = 4,
  parameter int NBANKS   = 4,
  parameter bit VERTICAL = 1'b0,
  parameter bit COMBINE  = 1'b1,
  parameter int CNT_W    = 16,
  localparam int AW      = $clog2(DEPTH),
  localparam int SW      = $clog2(NBANKS),
  localparam int ROWS    = VERTICAL ? DEPTH : DEPTH / NBANKS,
  localparam int COLS    = VERTICAL ? WIDTH / NBANKS : WIDTH,
  localparam int RW      = $clog2(ROWS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    wr_ce,
  input  logic [AW-1:0]           wr_addr,
  input  logic [WIDTH-1:0]        wr_data,
  input  logic                    rd_en,
  input  logic                    rd_ce,
  input  logic [AW-1:0]           rd_addr,
  output logic [WIDTH-1:0]        rd_data,
  output logic [NBANKS*CNT_W-1:0] wr_cnt_o,
  output logic [NBANKS*CNT_W-1:0] rd_cnt_o
);
  // named internal events for the assertions
  logic              wr_go, rd_go;
  logic [SW-1:0]     wr_sel, rd_sel, rd_sel_q;
  logic [NBANKS-1:0] wr_bank_en, rd_bank_en;
  logic [COLS-1:0]   bank_rd [NBANKS];

  bank_enable_ctl #(.AW(AW), .NBANKS(NBANKS), .VERTICAL(VERTICAL), .COMBINE(COMBINE)) u_wctl (
    .en(wr_en), .ce(wr_ce), .addr(wr_addr), .go(wr_go), .sel(wr_sel), .bank_en(wr_bank_en));

  bank_enable_ctl #(.AW(AW), .NBANKS(NBANKS), .VERTICAL(VERTICAL), .COMBINE(COMBINE)) u_rctl (
    .en(rd_en), .ce(rd_ce), .addr(rd_addr), .go(rd_go), .sel(rd_sel), .bank_en(rd_bank_en));

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic [COLS-1:0] wslice;
    if (VERTICAL) begin : g_slice
      assign wslice = wr_data[b*COLS +: COLS];
    end else begin : g_word
      assign wslice = wr_data;
    end
    ram_bank #(.ROWS(ROWS), .COLS(COLS), .CNT_W(CNT_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .we(wr_bank_en[b]), .waddr(wr_addr[RW-1:0]), .wdata(wslice),
      .re(rd_bank_en[b]), .raddr(rd_addr[RW-1:0]), .rdata(bank_rd[b]),
      .wr_cnt(wr_cnt_o[b*CNT_W +: CNT_W]), .rd_cnt(rd_cnt_o[b*CNT_W +: CNT_W]));
  end

  // bank of the last accepted read, steering the output multiplexer
  always_ff @(posedge clk) begin
    if (!rst_n)     rd_sel_q <= '0;
    else if (rd_go) rd_sel_q <= rd_sel;
  end

  if (VERTICAL) begin : g_vout
    for (genvar b = 0; b < NBANKS; b++) begin : g_join
      assign rd_data[b*COLS +: COLS] = bank_rd[b];
    end
  end else begin : g_hout
    assign rd_data = bank_rd[rd_sel_q];
  end

  assert_one_wr_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !VERTICAL |-> $countones(wr_bank_en) <= 1);
  assert_one_rd_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !VERTICAL |-> $onehot0(rd_bank_en));
  assert_rd_sel_track_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!VERTICAL && rd_go) |=> rd_sel_q == $past(rd_addr[AW-1 -: SW]));
  assert_idle_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_go |=> $stable(wr_cnt_o));
  assert_hold_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |=> $stable(rd_data));
  assert_all_banks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (VERTICAL && rd_go) |-> &rd_bank_en);
endmodule

// File: tb/sim_banked_ram.sv
module sim_banked_ram;
  localparam int CW = 16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 0, wce = 0, re = 0, rce = 0;
  logic [11:0] wa = 0, ra = 0;
  logic [3:0]  wd = 0;
  logic [3:0]  rdo [3];
  logic [4*CW-1:0] wc [3];
  logic [4*CW-1:0] rc [3];

  int checks = 0, failures = 0;
  logic [3:0] mem_c [int];   // model with user clock enables honoured
  logic [3:0] mem_v [int];   // model with user clock enables ignored
  logic [3:0] exp_rd [3];
  bit         known [3];
  int         expw [3][4];
  int         expr [3][4];

  always #5 clk = ~clk;

  banked_ram u0 (.clk(clk), .rst_n(rst_n), .wr_en(we), .wr_ce(wce), .wr_addr(wa), .wr_data(wd),
    .rd_en(re), .rd_ce(rce), .rd_addr(ra), .rd_data(rdo[0]), .wr_cnt_o(wc[0]), .rd_cnt_o(rc[0]));
  banked_ram #(.COMBINE(1'b0)) u1 (.clk(clk), .rst_n(rst_n), .wr_en(we), .wr_ce(wce), .wr_addr(wa),
    .wr_data(wd), .rd_en(re), .rd_ce(rce), .rd_addr(ra), .rd_data(rdo[1]), .wr_cnt_o(wc[1]),
    .rd_cnt_o(rc[1]));
  banked_ram #(.VERTICAL(1'b1)) u2 (.clk(clk), .rst_n(rst_n), .wr_en(we), .wr_ce(wce), .wr_addr(wa),
    .wr_data(wd), .rd_en(re), .rd_ce(rce), .rd_addr(ra), .rd_data(rdo[2]), .wr_cnt_o(wc[2]),
    .rd_cnt_o(rc[2]));

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // compares all outputs against the model, then drives one cycle and advances the model
  task automatic step(input bit w, input int a_w, input int d, input bit wc_e,
                      input bit r, input int a_r, input bit rc_e);
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      string ctag;
      ctag = (i == 0) ? "R3" : (i == 1) ? "R6" : "R9";
      if (known[i]) chk(rdo[i] == exp_rd[i], "R2", $sformatf("rd_data u%0d", i), rdo[i], exp_rd[i]);
      for (int b = 0; b < 4; b++) begin
        chk(int'(wc[i][b*CW +: CW]) == expw[i][b], ctag, $sformatf("wr_cnt u%0d bank%0d", i, b),
            int'(wc[i][b*CW +: CW]), expw[i][b]);
        chk(int'(rc[i][b*CW +: CW]) == expr[i][b], ctag, $sformatf("rd_cnt u%0d bank%0d", i, b),
            int'(rc[i][b*CW +: CW]), expr[i][b]);
      end
    end
    we = w; wa = 12'(a_w); wd = 4'(d); wce = wc_e;
    re = r; ra = 12'(a_r); rce = rc_e;
    for (int i = 0; i < 3; i++) begin
      bit wg, rg;
      wg = (i == 1) ? w : (w && wc_e);   // R5 / R6
      rg = (i == 1) ? r : (r && rc_e);
      if (rg) begin
        if (i == 1) begin
          known[i] = mem_v.exists(a_r);
          if (known[i]) exp_rd[i] = mem_v[a_r];
        end else begin
          known[i] = mem_c.exists(a_r);
          if (known[i]) exp_rd[i] = mem_c[a_r];
        end
        for (int b = 0; b < 4; b++) if (i == 2 || b == (a_r >> 10)) expr[i][b]++;
      end
      if (wg) for (int b = 0; b < 4; b++) if (i == 2 || b == (a_w >> 10)) expw[i][b]++;
    end
    // writes land after the reads above: R8 read-before-write
    if (w && wc_e) mem_c[a_w] = 4'(d);
    if (w) mem_v[a_w] = 4'(d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) begin
      exp_rd[i] = '0; known[i] = 1'b1;   // R11 reset state
      for (int b = 0; b < 4; b++) begin expw[i][b] = 0; expr[i][b] = 0; end
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0);
    // R1: one word in each bank via bits [11:10]
    step(1, 12'h005, 4'h3, 1, 0, 0, 0);
    step(1, 12'h405, 4'h6, 1, 0, 0, 0);
    step(1, 12'h805, 4'h9, 1, 0, 0, 0);
    step(1, 12'hC05, 4'hC, 1, 0, 0, 0);
    // R2: read back each bank
    step(0, 0, 0, 0, 1, 12'h005, 1);
    step(0, 0, 0, 0, 1, 12'h405, 1);
    step(0, 0, 0, 0, 1, 12'h805, 1);
    step(0, 0, 0, 0, 1, 12'hC05, 1);
    // R5 / R6: write with clock enable low
    step(1, 12'h005, 4'hF, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 12'h005, 1);
    // R7: idle cycles hold the output
    step(0, 0, 0, 0, 0, 12'h805, 1);
    step(0, 0, 0, 0, 0, 0, 0);
    // R5: read with clock enable low holds u0/u2, u1 still reads
    step(0, 0, 0, 0, 1, 12'h405, 0);
    // R4: enable low with clock enable high does nothing
    step(0, 12'h805, 4'h1, 1, 0, 12'h805, 1);
    step(0, 0, 0, 0, 1, 12'h805, 1);
    // R8: same address written and read together returns old word
    step(1, 12'h405, 4'hA, 1, 1, 12'h405, 1);
    step(0, 0, 0, 0, 1, 12'h405, 1);
    // R3: write one bank while reading another
    step(1, 12'hC05, 4'h2, 1, 1, 12'h005, 1);
    // mixed traffic on a small address pool (R2, R3, R9)
    for (int n = 0; n < 600; n++) begin
      int aw_i, ar_i;
      aw_i = (int'($urandom_range(3)) << 10) | int'($urandom_range(7));
      ar_i = (int'($urandom_range(3)) << 10) | int'($urandom_range(7));
      if (n % 37 == 0) ar_i = aw_i;
      step($urandom_range(1) == 1, aw_i, int'($urandom_range(15)), $urandom_range(3) != 0,
           $urandom_range(1) == 1, ar_i, $urandom_range(3) != 0);
    end
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule